// File: doc/BRIEF.md
# Oscillator Tuning Word Conditioner

This block sits between a digital phase-locked loop and the switched-capacitor tuning banks of a digitally controlled oscillator. Each reference clock cycle it takes one signed tuning word and a two-bit lock-phase mode. It steers the word to exactly one group of bank controls: the binary-weighted process-calibration bank, the acquisition bank, or the pair of integer and fractional tracking banks. A fourth mode freezes everything.

The word is split into a signed integer part, which is its upper bits, and an unsigned fractional part, which is its low `FRAC_W` bits. The integer part is moved from signed to unsigned form by adding half of the target bank's range. The result is clamped at zero and at the bank's top code rather than wrapped. The acquisition and integer-tracking codes then become thermometer enables, while the calibration code stays binary. The fractional bits go out unchanged to a separate dithering stage. A bank that is not selected keeps its last value, which is how a coarse bank stays frozen once its locking phase is over.

Top module: `otw_cond`

## Requirements
- R1: A synchronous reset, sampled at a rising clock edge, sets every bank to mid-scale from the following cycle. Calibration becomes 2^(PCAL_W-1). The acquisition and integer-tracking enables get their lowest 2^(W-1) bits set. The fractional output becomes 2^(FRAC_W-1).
- R2: With mode 2'b00, the calibration output becomes clamp(I + 2^(PCAL_W-1), 0, 2^PCAL_W-1), where I is the signed value of tune_word[TW_W-1:FRAC_W]. All other outputs keep their values.
- R3: With mode 2'b01, the acquisition enables become the thermometer form of clamp(I + 2^(ACQ_W-1), 0, 2^ACQ_W-1). All other outputs keep their values.
- R4: With mode 2'b10, the integer-tracking enables become the thermometer form of clamp(I + 2^(TRKI_W-1), 0, 2^TRKI_W-1). The fractional output becomes tune_word[FRAC_W-1:0]. The calibration and acquisition outputs keep their values.
- R5: With mode 2'b11, no output changes.
- R6: An integer part below minus half a bank's range produces code 0: a zero calibration code, or all enables of a thermometer bank cleared.
- R7: An integer part at or above half a bank's range produces that bank's top code: all ones.
- R8: A thermometer output with code N has exactly bits 0 to N-1 set and all higher bits clear.
- R9: Mode and tuning word sampled at a rising edge show on the outputs right after that edge, which is one cycle of latency. A mode change therefore acts at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Lock phase: 00 calibration, 01 acquisition, 10 tracking, 11 hold |
| tune_word | input | TW_W | Signed tuning word, low FRAC_W bits fractional |
| pcal_code | output | PCAL_W | Binary calibration bank code |
| acq_en | output | 2^ACQ_W-1 | Thermometer acquisition bank enables |
| trki_en | output | 2^TRKI_W-1 | Thermometer integer tracking enables |
| trkf_frac | output | FRAC_W | Fractional bits for the dither stage |

## Verification
Every result is registered once, so a mode and word driven before a rising edge are reflected on the outputs right after that edge and nowhere earlier. The bench drives on the falling edge, advances its reference model just after the rising edge, and compares all four outputs at the next falling edge. Each comparison therefore covers exactly one sampled mode and word. The banks that were not selected are compared in the same cycle to confirm they kept their values.

// File: rtl/otw_cond.sv
module otw_cond #(
  parameter int TW_W   = 16,
  parameter int FRAC_W = 8,
  parameter int PCAL_W = 7,
  parameter int ACQ_W  = 5,
  parameter int TRKI_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              mode,
  input  logic [TW_W-1:0]         tune_word,
  output logic [PCAL_W-1:0]       pcal_code,
  output logic [2**ACQ_W-2:0]     acq_en,
  output logic [2**TRKI_W-2:0]    trki_en,
  output logic [FRAC_W-1:0]       trkf_frac
);
  localparam int INT_W   = TW_W - FRAC_W;
  localparam int ACQ_N   = 2**ACQ_W - 1;
  localparam int TRKI_N  = 2**TRKI_W - 1;
  localparam int PCAL_MX = 2**PCAL_W - 1;
  localparam logic [PCAL_W-1:0] PCAL_MID = PCAL_W'(2**(PCAL_W-1));
  localparam logic [ACQ_N-1:0]  ACQ_MID  = {ACQ_N{1'b1}} >> (ACQ_N - 2**(ACQ_W-1));
  localparam logic [TRKI_N-1:0] TRKI_MID = {TRKI_N{1'b1}} >> (TRKI_N - 2**(TRKI_W-1));
  localparam logic [FRAC_W-1:0] FRAC_MID = FRAC_W'(2**(FRAC_W-1));

  localparam logic [1:0] M_PCAL = 2'b00;
  localparam logic [1:0] M_ACQ  = 2'b01;
  localparam logic [1:0] M_TRK  = 2'b10;

  logic signed [INT_W-1:0] tw_int;
  int pcal_sum, acq_sum, trki_sum;
  logic [PCAL_W-1:0] pcal_next;
  logic [ACQ_W-1:0]  acq_code;
  logic [TRKI_W-1:0] trki_code;
  logic [ACQ_N-1:0]  acq_next;
  logic [TRKI_N-1:0] trki_next;

  assign tw_int   = tune_word[TW_W-1:FRAC_W];
  assign pcal_sum = int'(tw_int) + 2**(PCAL_W-1);
  assign acq_sum  = int'(tw_int) + 2**(ACQ_W-1);
  assign trki_sum = int'(tw_int) + 2**(TRKI_W-1);

  assign pcal_next = (pcal_sum < 0) ? '0 : (pcal_sum > PCAL_MX) ? '1 : pcal_sum[PCAL_W-1:0];
  assign acq_code  = (acq_sum < 0)  ? '0 : (acq_sum > ACQ_N)    ? '1 : acq_sum[ACQ_W-1:0];
  assign trki_code = (trki_sum < 0) ? '0 : (trki_sum > TRKI_N)  ? '1 : trki_sum[TRKI_W-1:0];

  for (genvar i = 0; i < ACQ_N; i++) begin : g_acq_th
    assign acq_next[i] = acq_code > ACQ_W'(i);
  end
  for (genvar i = 0; i < TRKI_N; i++) begin : g_trki_th
    assign trki_next[i] = trki_code > TRKI_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcal_code <= PCAL_MID;
      acq_en    <= ACQ_MID;
      trki_en   <= TRKI_MID;
      trkf_frac <= FRAC_MID;
    end else begin
      if (mode == M_PCAL) pcal_code <= pcal_next;
      if (mode == M_ACQ)  acq_en    <= acq_next;
      if (mode == M_TRK) begin
        trki_en   <= trki_next;
        trkf_frac <= tune_word[FRAC_W-1:0];
      end
    end
  end
endmodule

module otw_cond_chk #(
  parameter int TW_W   = 16,
  parameter int FRAC_W = 8,
  parameter int PCAL_W = 7,
  parameter int ACQ_W  = 5,
  parameter int TRKI_W = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           mode,
  input logic [TW_W-1:0]      tune_word,
  input logic [PCAL_W-1:0]    pcal_code,
  input logic [2**ACQ_W-2:0]  acq_en,
  input logic [2**TRKI_W-2:0] trki_en,
  input logic [FRAC_W-1:0]    trkf_frac
);
  localparam int ACQ_N  = 2**ACQ_W - 1;
  localparam int TRKI_N = 2**TRKI_W - 1;

  // R2
  pcal_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b00) |-> ($stable(acq_en) && $stable(trki_en) && $stable(trkf_frac)));
  // R3
  acq_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b01) |-> ($stable(pcal_code) && $stable(trki_en) && $stable(trkf_frac)));
  // R4
  trk_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b10) |-> ($stable(pcal_code) && $stable(acq_en)));
  // R4
  frac_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b10) |-> (trkf_frac == $past(tune_word[FRAC_W-1:0])));
  // R5
  hold_all_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b11) |-> ($stable(pcal_code) && $stable(acq_en) && $stable(trki_en) && $stable(trkf_frac)));
  // R8
  acq_therm_chk: assert property (@(posedge clk) disable iff (rst)
    (acq_en & (acq_en + ACQ_N'(1))) == '0);
  // R8
  trki_therm_chk: assert property (@(posedge clk) disable iff (rst)
    (trki_en & (trki_en + TRKI_N'(1))) == '0);
endmodule

bind otw_cond otw_cond_chk #(
  .TW_W(TW_W), .FRAC_W(FRAC_W), .PCAL_W(PCAL_W), .ACQ_W(ACQ_W), .TRKI_W(TRKI_W)
) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .tune_word(tune_word),
  .pcal_code(pcal_code), .acq_en(acq_en), .trki_en(trki_en), .trkf_frac(trkf_frac)
);

// File: tb/otw_cond_tb.sv
module otw_cond_tb;
  localparam int TW_W = 16, FRAC_W = 8, PCAL_W = 7, ACQ_W = 5, TRKI_W = 6;
  localparam int ACQ_N = 2**ACQ_W - 1, TRKI_N = 2**TRKI_W - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b11;
  logic [TW_W-1:0] tune_word = '0;
  logic [PCAL_W-1:0] pcal_code;
  logic [ACQ_N-1:0] acq_en;
  logic [TRKI_N-1:0] trki_en;
  logic [FRAC_W-1:0] trkf_frac;

  int checks = 0, fails = 0;
  int e_pcal, e_acq, e_trki, e_frac;
  bit done = 0;

  always #5 clk = ~clk;

  otw_cond u_dut (
    .clk(clk), .rst(rst), .mode(mode), .tune_word(tune_word),
    .pcal_code(pcal_code), .acq_en(acq_en), .trki_en(trki_en), .trkf_frac(trkf_frac)
  );

  function automatic int clampv(int v, int w);
    int mx = (1 << w) - 1;
    int s = v + (1 << (w - 1));
    return (s < 0) ? 0 : (s > mx) ? mx : s;
  endfunction

  function automatic logic [63:0] therm(int n);
    logic [63:0] t = '0;
    for (int i = 0; i < 64; i++) if (i < n) t[i] = 1'b1;
    return t;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [63:0] ta = therm(e_acq);
    logic [63:0] tt = therm(e_trki);
    check({tag, " pcal"}, 64'(pcal_code), 64'(e_pcal));
    check({tag, " acq"},  64'(acq_en), 64'(ta[ACQ_N-1:0]));
    check({tag, " trki"}, 64'(trki_en), 64'(tt[TRKI_N-1:0]));
    check({tag, " frac"}, 64'(trkf_frac), 64'(e_frac));
  endtask

  // drive at a falling edge, update model after the rising edge, compare at the next falling edge (R9)
  task automatic step(logic r, logic [1:0] m, logic [TW_W-1:0] w, string tag);
    int iv;
    rst = r; mode = m; tune_word = w;
    @(posedge clk); #1;
    iv = int'($signed(w[TW_W-1:FRAC_W]));
    if (r) begin
      e_pcal = 1 << (PCAL_W - 1); e_acq = 1 << (ACQ_W - 1);
      e_trki = 1 << (TRKI_W - 1); e_frac = 1 << (FRAC_W - 1);
    end else begin
      case (m)
        2'b00: e_pcal = clampv(iv, PCAL_W);
        2'b01: e_acq  = clampv(iv, ACQ_W);
        2'b10: begin e_trki = clampv(iv, TRKI_W); e_frac = int'(w[FRAC_W-1:0]); end
        default: ;
      endcase
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd20517);
    @(negedge clk);
    step(1'b1, 2'b11, 16'h0000, "R1 reset");
    step(1'b1, 2'b00, 16'h7FFF, "R1 reset ignores mode");
    step(1'b0, 2'b11, 16'h5A5A, "R5 hold");
    // R2 calibration value, other banks untouched
    step(1'b0, 2'b00, 16'h0A00, "R2 pcal");
    // R3 acquisition value
    step(1'b0, 2'b01, 16'hFD00, "R3 acq");
    // R4 tracking integer and fraction
    step(1'b0, 2'b10, 16'h05C3, "R4 trk");
    // R6 low saturation on every bank
    step(1'b0, 2'b00, 16'h8000, "R6 pcal low");
    step(1'b0, 2'b01, 16'hEF00, "R6 acq low");
    step(1'b0, 2'b10, 16'hDF00, "R6 trki low");
    // boundary: exactly minus half range gives code 0 (R6), minus half plus one gives 1 (R8)
    step(1'b0, 2'b01, 16'hF000, "R6 acq edge");
    step(1'b0, 2'b01, 16'hF100, "R8 acq one");
    // R7 high saturation
    step(1'b0, 2'b00, 16'h7F00, "R7 pcal high");
    step(1'b0, 2'b01, 16'h1000, "R7 acq high");
    step(1'b0, 2'b10, 16'h2000, "R7 trki high");
    step(1'b0, 2'b01, 16'h0F00, "R7 acq top");
    step(1'b0, 2'b11, 16'h0000, "R5 hold after sat");
    // R9 back-to-back mode changes take effect one edge later
    step(1'b0, 2'b00, 16'h0100, "R9 seq pcal");
    step(1'b0, 2'b01, 16'h0200, "R9 seq acq");
    step(1'b0, 2'b10, 16'h03FF, "R9 seq trk");
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] m = 2'($urandom_range(0, 3));
      logic [TW_W-1:0] w;
      case ($urandom_range(0, 3))
        0: w = TW_W'($urandom);
        1: w = {8'($urandom_range(0, 40) - 20), 8'($urandom)};
        2: w = {8'($urandom_range(0, 80) - 40), 8'($urandom)};
        default: w = {8'($urandom_range(0, 160) - 80), 8'($urandom)};
      endcase
      case (m)
        2'b00: step(1'b0, m, w, "R2/R9 rand");
        2'b01: step(1'b0, m, w, "R3/R8 rand");
        2'b10: step(1'b0, m, w, "R4/R8 rand");
        default: step(1'b0, m, w, "R5 rand");
      endcase
    end
    step(1'b1, 2'b10, 16'h1234, "R1 late reset");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule